// File: doc/BRIEF.md
# OTP Protection Register Controller

This block is synthesizable logic for the one-time-programmable protection area of a parallel flash part. Bus writes carry a 16-bit word and an address, and bus reads are 16 bits wide. A two-write program sequence stores a word into an OTP data location or into one of two lock words. Each lock bit guards one segment of OTP data and can only be cleared. After a lock bit is cleared, any program sent to its segment is refused, and the refusal is reported through sticky status bits.

The protection window begins at word offset 0x80. Lock word A sits at 0x80. It is followed by the first 128-bit register, split into a lower half at 0x81-0x84 and an upper half at 0x85-0x88. Lock word B sits at 0x89. Sixteen more 128-bit registers follow at 0x8A-0x109, eight words each. Program cycles can only turn 1s into 0s, and erased storage reads as 0xFFFF.

Top module: `otp_prot_ctrl`

## Requirements
- R1: After reset, data words read 0xFFFF, lock word A (0x80) reads 0xFFFE, lock word B (0x89) reads 0xFFFF, and the bus is in register-read mode.
- R2: A program is a write of low byte 0xC0 to an address inside 0x80-0x109, followed by a data write to that same address. After the data write the bus is in status-read mode.
- R3: A program stores the old word ANDed with the written data, so a bit at 0 never returns to 1.
- R4: A 0xC0 write to an address outside 0x80-0x109 sets status bit 4 and arms nothing, so the following write is decoded as a command.
- R5: A program to a word of a locked segment leaves the word unchanged and sets status bits 4 and 1. Status reads as 0x0092.
- R6: Lock words at 0x80 and 0x89 are programmed with the same two-write sequence and AND rule. A cleared lock bit is never set again.
- R7: Lock word A bit 0 is cleared at reset and locks 0x81-0x84. Clearing bit 1 (data 0xFFFD) locks 0x85-0x88.
- R8: Lock word B bit k locks the words 0x8A+8k through 0x91+8k.
- R9: The status word has bit 7 = 1 (ready), bit 4 = program error and bit 1 = lock error. The error bits stay set until a 0x50 write. A 0x70 write selects status-read mode and a 0xFF write selects register-read mode.
- R10: A write whose low byte is not a known command leaves all state unchanged. A data write whose address differs from the armed address sets bit 4 and writes nothing.
- R11: A read pulse loads rdata on the next clock, and rdata holds its value when no read is pulsed. Register reads outside the window return 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write cycle strobe |
| rd_en | input | 1 | Read cycle strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data or command |
| rdata | output | 16 | Read data, valid the cycle after rd_en |

## Verification
Programs are driven at three kinds of address: unlocked words, words in locked segments, and addresses outside the window. This separates a real write from a lock refusal and from a range refusal. Repeated programs to the same word, using data with mixed set and clear bits, show that the result is the AND of old and new data and not an overwrite. Programs that straddle segment boundaries (the last word of one register and the first word of the next) show that each lock bit covers exactly its own eight or four words. Error, clear and mode-change sequences then show that the status bits are sticky and that the read mode switches correctly.

// File: rtl/otp_pkg.sv
package otp_pkg;
    typedef enum logic [1:0] {
        K_NONE  = 2'd0,
        K_LOCKA = 2'd1,
        K_LOCKB = 2'd2,
        K_DATA  = 2'd3
    } otp_kind_e;

    localparam logic [7:0] CMD_PROG  = 8'hC0;
    localparam logic [7:0] CMD_STAT  = 8'h70;
    localparam logic [7:0] CMD_CLEAR = 8'h50;
    localparam logic [7:0] CMD_READ  = 8'hFF;

    localparam int SR_READY = 7;
    localparam int SR_PERR  = 4;
    localparam int SR_LERR  = 1;
endpackage

// File: rtl/otp_addr_map.sv
module otp_addr_map
    import otp_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int BASE    = 'h80,
    parameter int NUM_BIG = 16,
    parameter int WPR     = 8,
    parameter int IDX_W   = 8,
    parameter int LSEL_W  = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output otp_kind_e         kind,
    output logic [IDX_W-1:0]  idx,
    output logic [LSEL_W-1:0] lsel
);
    localparam logic [ADDR_W-1:0] A_LOCKA = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] A_FIRST = ADDR_W'(BASE + 1);
    localparam logic [ADDR_W-1:0] A_LOCKB = ADDR_W'(BASE + 1 + WPR);
    localparam logic [ADDR_W-1:0] A_BIGLO = ADDR_W'(BASE + 2 + WPR);
    localparam logic [ADDR_W-1:0] A_END   = ADDR_W'(BASE + 1 + WPR + NUM_BIG * WPR);
    localparam logic [ADDR_W-1:0] HALF    = ADDR_W'(WPR / 2);
    localparam logic [ADDR_W-1:0] WPR_A   = ADDR_W'(WPR);

    logic [ADDR_W-1:0] off;

    always_comb begin
        kind = K_NONE;
        idx  = '0;
        lsel = '0;
        off  = '0;
        if (addr == A_LOCKA) begin
            kind = K_LOCKA;
        end else if (addr == A_LOCKB) begin
            kind = K_LOCKB;
        end else if (addr >= A_FIRST && addr < A_LOCKB) begin
            kind = K_DATA;
            off  = addr - A_FIRST;
            idx  = IDX_W'(off);
            lsel = (off >= HALF) ? LSEL_W'(1) : LSEL_W'(0);
        end else if (addr >= A_BIGLO && addr <= A_END) begin
            kind = K_DATA;
            off  = addr - A_BIGLO;
            idx  = IDX_W'(off + WPR_A);
            lsel = LSEL_W'(off / WPR_A + ADDR_W'(2));
        end
    end
endmodule

// File: rtl/otp_lock_check.sv
module otp_lock_check #(
    parameter int NUM_BIG = 16,
    parameter int LSEL_W  = 5
) (
    input  logic [15:0]       lock_a,
    input  logic [15:0]       lock_b,
    input  logic [LSEL_W-1:0] lsel,
    input  logic              is_data,
    output logic              locked
);
    localparam int NBITS = NUM_BIG + 2;

    logic [NBITS-1:0] open_bits;

    assign open_bits[0] = lock_a[0];
    assign open_bits[1] = lock_a[1];

    for (genvar g = 0; g < NUM_BIG; g++) begin : g_big
        assign open_bits[g + 2] = lock_b[g];
    end

    always_comb begin
        locked = 1'b0;
        if (is_data) begin
            locked = 1'b1;
            for (int i = 0; i < NBITS; i++) begin
                if (LSEL_W'(i) == lsel) locked = !open_bits[i];
            end
        end
    end
endmodule

// File: rtl/otp_store.sv
module otp_store #(
    parameter int DEPTH = 136,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_en,
    input  logic [IDX_W-1:0] prog_idx,
    input  logic [15:0]      prog_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [15:0]      rd_word
);
    logic [15:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 16'hFFFF;
        end else if (prog_en) begin
            mem_q[prog_idx] <= mem_q[prog_idx] & prog_data;
        end
    end

    assign rd_word = (int'(rd_idx) < DEPTH) ? mem_q[rd_idx] : 16'hFFFF;

    // R3: a programmed word never gains a 1 bit
    a_r3_and_only: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |=> ((mem_q[$past(prog_idx)] & ~$past(mem_q[prog_idx])) == 16'h0000));

    // R2: program index stays inside storage
    a_r2_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |-> (int'(prog_idx) < DEPTH));
endmodule

// File: rtl/otp_prot_ctrl.sv
module otp_prot_ctrl
    import otp_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int BASE    = 'h80,
    parameter int NUM_BIG = 16,
    parameter int WPR     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata
);
    localparam int DEPTH  = WPR * (NUM_BIG + 1);
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int LSEL_W = $clog2(NUM_BIG + 2);

    typedef struct packed {
        logic              pend;
        logic [ADDR_W-1:0] paddr;
        logic              stat_mode;
        logic              perr;
        logic              lerr;
        logic [15:0]       lock_a;
        logic [15:0]       lock_b;
        logic [15:0]       rdata;
    } st_t;

    st_t st_d, st_q;

    otp_kind_e         kind;
    logic [IDX_W-1:0]  idx;
    logic [LSEL_W-1:0] lsel;
    logic              locked;
    logic              st_we;
    logic [15:0]       st_word;
    logic [15:0]       status;

    otp_addr_map #(
        .ADDR_W(ADDR_W), .BASE(BASE), .NUM_BIG(NUM_BIG), .WPR(WPR),
        .IDX_W(IDX_W), .LSEL_W(LSEL_W)
    ) u_map (
        .addr(addr), .kind(kind), .idx(idx), .lsel(lsel)
    );

    otp_lock_check #(.NUM_BIG(NUM_BIG), .LSEL_W(LSEL_W)) u_lock (
        .lock_a(st_q.lock_a), .lock_b(st_q.lock_b), .lsel(lsel),
        .is_data(kind == K_DATA), .locked(locked)
    );

    otp_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .prog_en(st_we), .prog_idx(idx),
        .prog_data(wdata), .rd_idx(idx), .rd_word(st_word)
    );

    always_comb begin
        status           = 16'h0000;
        status[SR_READY] = 1'b1;
        status[SR_PERR]  = st_q.perr;
        status[SR_LERR]  = st_q.lerr;
    end

    always_comb begin
        st_d  = st_q;
        st_we = 1'b0;
        if (rd_en) begin
            if (st_q.stat_mode) begin
                st_d.rdata = status;
            end else begin
                case (kind)
                    K_LOCKA: st_d.rdata = st_q.lock_a;
                    K_LOCKB: st_d.rdata = st_q.lock_b;
                    K_DATA:  st_d.rdata = st_word;
                    default: st_d.rdata = 16'h0000;
                endcase
            end
        end
        if (wr_en) begin
            if (st_q.pend) begin
                st_d.pend      = 1'b0;
                st_d.stat_mode = 1'b1;
                if (addr != st_q.paddr) begin
                    st_d.perr = 1'b1;
                end else begin
                    case (kind)
                        K_LOCKA: st_d.lock_a = st_q.lock_a & wdata;
                        K_LOCKB: st_d.lock_b = st_q.lock_b & wdata;
                        K_DATA: begin
                            if (locked) begin
                                st_d.perr = 1'b1;
                                st_d.lerr = 1'b1;
                            end else begin
                                st_we = 1'b1;
                            end
                        end
                        default: st_d.perr = 1'b1;
                    endcase
                end
            end else begin
                case (wdata[7:0])
                    CMD_PROG: begin
                        if (kind == K_NONE) begin
                            st_d.perr      = 1'b1;
                            st_d.stat_mode = 1'b1;
                        end else begin
                            st_d.pend  = 1'b1;
                            st_d.paddr = addr;
                        end
                    end
                    CMD_STAT:  st_d.stat_mode = 1'b1;
                    CMD_CLEAR: begin
                        st_d.perr = 1'b0;
                        st_d.lerr = 1'b0;
                    end
                    CMD_READ:  st_d.stat_mode = 1'b0;
                    default:   ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend      <= 1'b0;
            st_q.paddr     <= '0;
            st_q.stat_mode <= 1'b0;
            st_q.perr      <= 1'b0;
            st_q.lerr      <= 1'b0;
            st_q.lock_a    <= 16'hFFFE;
            st_q.lock_b    <= 16'hFFFF;
            st_q.rdata     <= 16'h0000;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;

    // R6: lock bits only ever go from 1 to 0
    a_r6_lock_one_way: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.lock_a & ~$past(st_q.lock_a)) == 16'h0000) &&
        ((st_q.lock_b & ~$past(st_q.lock_b)) == 16'h0000));

    // R7: the factory lock bit stays cleared
    a_r7_factory_lock: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.lock_a[0]);

    // R5: a lock error never appears without a program error
    a_r5_lock_implies_prog: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.lerr) |-> st_q.perr);

    // R4: an out-of-window program command flags an error and arms nothing
    a_r4_range_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !st_q.pend && wdata[7:0] == CMD_PROG && kind == K_NONE)
        |=> (st_q.perr && !st_q.pend));

    // R2: any write while armed consumes the pending program
    a_r2_one_data_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && st_q.pend) |=> (!st_q.pend && st_q.stat_mode));

    // R11: rdata holds when no read is issued
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> $stable(rdata));
endmodule

// File: tb/otp_prot_ctrl_test.sv
`timescale 1ns/1ps
module otp_prot_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;

    int compared = 0;
    int mismatched = 0;

    always #10 clk = ~clk;

    otp_prot_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    // {is_read, req, addr, value}: value is write data or expected read
    localparam int NV = 35;
    localparam logic [36:0] VEC [NV] = '{
        {1'b1, 4'd1,  16'h0090, 16'hFFFF},  // R1 erased data
        {1'b1, 4'd1,  16'h0080, 16'hFFFE},  // R1 lock word A
        {1'b1, 4'd1,  16'h0089, 16'hFFFF},  // R1 lock word B
        {1'b0, 4'd2,  16'h0090, 16'h00C0},  // R2 arm
        {1'b0, 4'd2,  16'h0090, 16'h1234},  // R2 data
        {1'b1, 4'd2,  16'h0090, 16'h0080},  // R2 now status mode
        {1'b0, 4'd9,  16'h0000, 16'h00FF},  // R9 register mode
        {1'b1, 4'd2,  16'h0090, 16'h1234},  // R2 stored
        {1'b0, 4'd3,  16'h0090, 16'h00C0},
        {1'b0, 4'd3,  16'h0090, 16'hFF00},
        {1'b0, 4'd3,  16'h0000, 16'h00FF},
        {1'b1, 4'd3,  16'h0090, 16'h1200},  // R3 AND rule
        {1'b0, 4'd7,  16'h0082, 16'h00C0},
        {1'b0, 4'd7,  16'h0082, 16'h0000},
        {1'b1, 4'd5,  16'h0000, 16'h0092},  // R5 both errors
        {1'b0, 4'd7,  16'h0000, 16'h00FF},
        {1'b1, 4'd7,  16'h0082, 16'hFFFF},  // R7 factory lock held
        {1'b0, 4'd9,  16'h0000, 16'h0050},
        {1'b0, 4'd9,  16'h0000, 16'h0070},
        {1'b1, 4'd9,  16'h0000, 16'h0080},  // R9 cleared
        {1'b0, 4'd7,  16'h0000, 16'h00FF},
        {1'b0, 4'd7,  16'h0086, 16'h00C0},
        {1'b0, 4'd7,  16'h0086, 16'hAAAA},
        {1'b0, 4'd7,  16'h0000, 16'h00FF},
        {1'b1, 4'd7,  16'h0086, 16'hAAAA},  // R7 upper half open
        {1'b0, 4'd6,  16'h0080, 16'h00C0},
        {1'b0, 4'd6,  16'h0080, 16'hFFFD},
        {1'b0, 4'd6,  16'h0000, 16'h00FF},
        {1'b1, 4'd6,  16'h0080, 16'hFFFC},  // R6 lock word programmed
        {1'b0, 4'd7,  16'h0086, 16'h00C0},
        {1'b0, 4'd7,  16'h0086, 16'h0000},
        {1'b1, 4'd7,  16'h0000, 16'h0092},  // R7 upper half locked
        {1'b0, 4'd7,  16'h0000, 16'h0050},
        {1'b0, 4'd7,  16'h0000, 16'h00FF},
        {1'b1, 4'd7,  16'h0086, 16'hAAAA}   // R7 word unchanged
    };

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input string req, input logic [15:0] a, input logic [15:0] exp);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(req, rdata, exp);
    endtask

    task automatic prog(input logic [15:0] a, input logic [15:0] d);
        wr(a, 16'h00C0);
        wr(a, d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rdata reset", rdata, 16'h0000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][36]) rd($sformatf("R%0d vec%0d", VEC[i][35:32], i), VEC[i][31:16], VEC[i][15:0]);
            else            wr(VEC[i][31:16], VEC[i][15:0]);
        end

        // R6: a cleared lock bit cannot be set again
        prog(16'h0080, 16'hFFFF);
        wr(16'h0000, 16'h00FF);
        rd("R6 no unlock", 16'h0080, 16'hFFFC);

        // R8: lock word B bit 3 covers 0xA2-0xA9 only
        prog(16'h0089, 16'hFFF7);
        wr(16'h0000, 16'h00FF);
        rd("R8 lock word B", 16'h0089, 16'hFFF7);
        prog(16'h00A2, 16'h0000);
        rd("R8 first word locked", 16'h0000, 16'h0092);
        wr(16'h0000, 16'h0050);
        prog(16'h00A9, 16'h0000);
        rd("R8 last word locked", 16'h0000, 16'h0092);
        wr(16'h0000, 16'h0050);
        wr(16'h0000, 16'h00FF);
        rd("R8 A2 unchanged", 16'h00A2, 16'hFFFF);
        rd("R8 A9 unchanged", 16'h00A9, 16'hFFFF);
        prog(16'h00AA, 16'h5555);
        prog(16'h00A1, 16'h0F0F);
        prog(16'h0109, 16'h0001);
        rd("R8 status clean", 16'h0000, 16'h0080);
        wr(16'h0000, 16'h00FF);
        rd("R8 next reg open", 16'h00AA, 16'h5555);
        rd("R8 prev reg open", 16'h00A1, 16'h0F0F);
        rd("R8 last window word", 16'h0109, 16'h0001);

        // R4: out-of-window commands
        prog(16'h007F, 16'h0000);
        rd("R4 below window", 16'h0000, 16'h0090);
        wr(16'h0000, 16'h0050);
        rd("R9 clear in status mode", 16'h0000, 16'h0080);
        wr(16'h010A, 16'h00C0);
        wr(16'h0090, 16'h0000);
        rd("R4 above window", 16'h0000, 16'h0090);
        wr(16'h0000, 16'h00FF);
        rd("R4 nothing armed", 16'h0090, 16'h1200);

        // R9: errors are sticky through a good program
        prog(16'h0093, 16'hF0F0);
        rd("R9 sticky", 16'h0000, 16'h0090);
        wr(16'h0000, 16'h0050);
        wr(16'h0000, 16'h00FF);
        rd("R9 good program landed", 16'h0093, 16'hF0F0);

        // R10: mismatched data address and unknown command
        wr(16'h0091, 16'h00C0);
        wr(16'h0092, 16'h0000);
        rd("R10 mismatch error", 16'h0000, 16'h0090);
        wr(16'h0000, 16'h0050);
        wr(16'h0000, 16'h00FF);
        rd("R10 91 unchanged", 16'h0091, 16'hFFFF);
        rd("R10 92 unchanged", 16'h0092, 16'hFFFF);
        wr(16'h0090, 16'h0020);
        rd("R10 unknown ignored", 16'h0090, 16'h1200);
        wr(16'h0000, 16'h0070);
        rd("R10 status clean", 16'h0000, 16'h0080);
        wr(16'h0000, 16'h00FF);

        // R11: out-of-window read and hold
        rd("R11 outside window", 16'h0010, 16'h0000);
        rd("R11 read again", 16'h0090, 16'h1200);
        @(negedge clk);
        addr = 16'h0091;
        repeat (3) @(negedge clk);
        check("R11 hold", rdata, 16'h1200);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule